// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a memory-mapped controller for the two-wire management bus that connects a MAC-side chip to its PHY devices. Software sets up a small register bank with the frame format (short-address or extended-address framing), the MDC clock divider, the port and register/device numbers and the outgoing data. It then writes the command register with the start bit and an access code. The block derives MDC from the system clock, shifts a complete 64-bit management frame out on MDIO, and releases the data line when a read hands control to the PHY. It captures the 16 returned bits and holds a busy flag high until the last bit has crossed the wire.

An extended-address (Clause 45) access uses two commands. The first is an address frame, which carries the write-data register as the 16-bit target register number. The second is a read or write frame to the device. For a write, software reloads the write-data register between the two commands. Software polls busy before it touches any register and before it reads the read-data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the mode register (offset 0x40) reads 0x000000FF. The address, write-data, read-data and command registers read 0. busy is 0, mdc is 1 and mdio_oe is 0.
- R2: Mode bit 8 selects the framing (0 = Clause 22, 1 = Clause 45). Mode bits 7:0 hold N, and one MDC period lasts N+1 system clocks. In each period MDC is low for (N+1)>>1 clocks and high for the rest.
- R3: The address register (0x44) keeps the port address in bits 12:8 and the register or device number in bits 4:0. The write-data register (0x48) keeps bits 15:0. The mode register keeps bits 8:0. All other bits read as 0.
- R4: A write to the command register (0x50) with bit 8 set starts a frame, and bits 1:0 give the access code. Bit 16 of the command register reads busy. Every frame is sent MSB first: 32 ones, start field, 2-bit opcode, 5-bit port, 5-bit register/device, 2-bit turnaround, 16 data bits.
- R5: In Clause 22 the start field is 01. Code bit 0 = 0 gives a read (opcode 10), and code bit 0 = 1 gives a write (opcode 01).
- R6: In Clause 45 the start field is 00. Code 0 gives an address frame (opcode 00), code 1 gives a write (opcode 01), and code 2 or 3 gives a read (opcode 11).
- R7: Write and address frames drive turnaround 10 and then write-data bits 15:0, with mdio_oe high for all 64 bits.
- R8: In a read frame mdio_oe is low from the first turnaround bit to the end. The 16 bits sampled at the MDC rising edges of the data phase land in read-data bits 15:0, bits 31:16 read 0, and write or address frames leave the register unchanged.
- R9: mdio_o and mdio_oe change only at the clock edge where MDC falls, or (mdio_oe only) at the end of the frame.
- R10: busy rises at the clock edge that accepts the start write. It stays high for exactly 63*(N+1)+((N+1)>>1)+1 clocks and falls at the last MDC rising edge.
- R11: A start write that arrives while busy is high has no effect on the frame in flight or its length.
- R12: While busy is low, MDC stays high without toggling and mdio_oe stays low.
- R13: With the reset divider (N = 255) a frame keeps busy high for 16257 clocks, and the MDC period is 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, registered one clock after bus_addr |
| busy | output | 1 | High while a frame is on the wire |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
A register read returns its value one clock after the address is applied. The bench samples bus_rdata on the next falling clock edge. busy rises at the edge that accepts the start write and falls 63*(N+1)+((N+1)>>1)+1 clocks later. A falling-edge monitor counts busy samples and compares them against that figure for N = 255, 15 and 7. The same monitor captures the line value in each MDC low phase and commits it as a frame bit at the next detected MDC rise, so a change at the closing edge cannot race the capture. Read data is fetched only after busy has been observed low plus one extra clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  typedef struct packed {
    logic        ext;    // 1 = Clause 45 framing
    logic [1:0]  code;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] data;
  } mdio_req_t;

  function automatic logic req_is_read(mdio_req_t r);
    return r.ext ? r.code[1] : !r.code[0];
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(mdio_req_t r);
    logic [1:0] st;
    logic [1:0] op;
    st = r.ext ? 2'b00 : 2'b01;
    if (r.ext) op = r.code[1] ? 2'b11 : (r.code[0] ? 2'b01 : 2'b00);
    else       op = r.code[0] ? 2'b01 : 2'b10;
    return {32'hFFFF_FFFF, st, op, r.port, r.dev, 2'b10, r.data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             fall_tick,
  output logic             rise_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W:0]   half;

  // A divider of 0 behaves as 1 so that the two edges never coincide.
  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign half    = ({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (rst || !run)         cnt <= '0;
    else if (cnt == div_eff) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  assign fall_tick = run && (cnt == '0);
  assign rise_tick = run && (cnt == half[DIV_W-1:0]);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             fall_tick,
  input  logic             rise_tick,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [15:0]      rd_data
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN-1);

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic                 is_rd;
  logic [15:0]          cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdc     <= 1'b1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      cap     <= '0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        shreg <= build_frame(req);
        is_rd <= req_is_read(req);
        idx   <= '0;
      end
    end else begin
      if (fall_tick) begin
        mdc     <= 1'b0;
        mdio_o  <= shreg[FRAME_LEN-1];
        shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
        mdio_oe <= !(is_rd && idx >= IDX_TA);
      end
      if (rise_tick) begin
        mdc <= 1'b1;
        idx <= idx + IDX_W'(1);
        if (is_rd && idx >= IDX_DATA) cap <= {cap[14:0], mdio_i};
        if (idx == IDX_LAST) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) rd_data <= {cap[14:0], mdio_i};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [15:0]       rd_word,
  output logic              start,
  output mdio_req_t         req,
  output logic [DIV_W-1:0]  div
);
  logic        ext_q;
  logic [4:0]  port_q;
  logic [4:0]  dev_q;
  logic [15:0] wdata_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q   <= 1'b0;
      div     <= '1;
      port_q  <= '0;
      dev_q   <= '0;
      wdata_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(OFS_MODE): begin
          ext_q <= bus_wdata[8];
          div   <= bus_wdata[DIV_W-1:0];
        end
        ADDR_W'(OFS_ADDR): begin
          port_q <= bus_wdata[12:8];
          dev_q  <= bus_wdata[4:0];
        end
        ADDR_W'(OFS_WDATA): wdata_q <= bus_wdata[15:0];
        default: ;
      endcase
    end
  end

  assign start = bus_wr && (bus_addr == ADDR_W'(OFS_CMD)) && bus_wdata[8];
  assign req   = '{ext: ext_q, code: bus_wdata[1:0], port: port_q,
                   dev: dev_q, data: wdata_q};

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_MODE):  rd_mux = DATA_W'({ext_q, div});
      ADDR_W'(OFS_ADDR):  rd_mux = DATA_W'({port_q, 3'b000, dev_q});
      ADDR_W'(OFS_WDATA): rd_mux = DATA_W'(wdata_q);
      ADDR_W'(OFS_RDATA): rd_mux = DATA_W'(rd_word);
      ADDR_W'(OFS_CMD):   rd_mux = DATA_W'({busy, 16'h0000});
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             start;
  mdio_req_t        req;
  logic [DIV_W-1:0] div;
  logic             fall_tick;
  logic             rise_tick;
  logic [15:0]      rd_word;

  mdio_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rd_word(rd_word), .start(start), .req(req), .div(div)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .div(div),
    .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .req(req),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .mdio_i(mdio_i),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  // R12: idle bus keeps the clock high and the line released
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));

  // R9: while MDC stays high the driven value and enable hold
  assert_drive_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R10: busy ends only on an MDC rising edge
  assert_end_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mdc && !$past(mdc)));

  // R4: a frame starts only after a start write to the command register
  assert_start_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && bus_addr == ADDR_W'(8'h50) && bus_wdata[8]));

  // R8: upper half of the read-data register stays zero
  assert_rdata_upper_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(8'h4C)) |-> (bus_rdata[DATA_W-1:16] == '0));
endmodule

bind mdio_mgmt_master mdio_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  mdio_mgmt_master u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model and frame monitor (falling clock edge) ----
  logic [15:0] phy_data = 16'h0000;
  logic [63:0] cap_frame;
  int k = 0;
  int busy_acc = 0;
  int rises = 0;
  int ncyc = 0;
  int rise1_cyc = 0;
  int period = 0;
  int low_n = 0;
  logic prev_mdc = 1'b1;
  logic prev_busy = 1'b0;
  logic line_last = 1'b1;
  logic oe_last = 1'b0;
  logic oe_bad_rd = 1'b0;
  logic oe_bad_wr = 1'b0;
  logic is_read_exp = 1'b0;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (busy && !prev_busy) begin
      k = 0; busy_acc = 0; rises = 0; period = 0; low_n = 0;
      cap_frame = '0; oe_bad_rd = 1'b0; oe_bad_wr = 1'b0;
    end
    if (busy) busy_acc = busy_acc + 1;
    if (mdc && !prev_mdc) begin
      if (k < 64) cap_frame[63-k] = line_last;
      if (k >= 46 && oe_last) oe_bad_rd = 1'b1;
      if (!oe_last) oe_bad_wr = 1'b1;
      k = k + 1;
      rises = rises + 1;
      if (rises == 1) rise1_cyc = ncyc;
      if (rises == 2) period = ncyc - rise1_cyc;
    end
    if (!mdc && prev_mdc) begin
      if (k < 47)       mdio_i = 1'b1;
      else if (k == 47) mdio_i = 1'b0;
      else if (k < 64)  mdio_i = phy_data[63-k];
      else              mdio_i = 1'b1;
    end
    if (!mdc) begin
      line_last = mdio_oe ? mdio_o : mdio_i;
      oe_last   = mdio_oe;
      if (rises == 1) low_n = low_n + 1;
    end
    prev_mdc  = mdc;
    prev_busy = busy;
  end

  // ---------------- helpers ----------------
  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input logic ext, input logic [1:0] code,
      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
      input logic [15:0] pd);
    logic [1:0] st, op;
    logic       rdop;
    st = ext ? 2'b00 : 2'b01;
    if (ext) begin
      rdop = (code >= 2'd2);
      op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
    end else begin
      rdop = !code[0];
      op = code[0] ? 2'b01 : 2'b10;
    end
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, rdop ? pd : wd};
  endfunction

  function automatic logic exp_read(input logic ext, input logic [1:0] code);
    return ext ? (code >= 2'd2) : !code[0];
  endfunction

  // {ext, code[1:0], port[4:0], dev[4:0], wdata[15:0], phy_data[15:0]}
  localparam logic [44:0] VEC [0:6] = '{
    {1'b0, 2'd0, 5'd1,  5'd2,  16'h0000, 16'hA5C3},
    {1'b0, 2'd1, 5'd31, 5'd31, 16'h1234, 16'h0000},
    {1'b1, 2'd0, 5'd3,  5'd1,  16'h0800, 16'hFFFF},
    {1'b1, 2'd1, 5'd3,  5'd1,  16'hBEEF, 16'h0000},
    {1'b1, 2'd2, 5'd3,  5'd1,  16'h0000, 16'h5AF0},
    {1'b0, 2'd1, 5'd0,  5'd0,  16'h0000, 16'hFFFF},
    {1'b1, 2'd3, 5'd16, 5'd30, 16'h0000, 16'h8001}
  };

  // ---------------- watchdog ----------------
  int wd_cyc = 0;
  always @(posedge clk) begin
    wd_cyc = wd_cyc + 1;
    if (wd_cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", wd_cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] r;
    logic [31:0] last_rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(busy == 1'b0 && mdc == 1'b1 && mdio_oe == 1'b0, "R1 pins", {busy, mdc, mdio_oe}, 3'b010);
    rd(8'h40, r); check(r == 32'h0000_00FF, "R1 mode", r, 32'hFF);
    rd(8'h44, r); check(r == 32'h0, "R1 addr", r, 0);
    rd(8'h4C, r); check(r == 32'h0, "R1 rdata", r, 0);
    rd(8'h50, r); check(r == 32'h0, "R1 cmd", r, 0);

    // R13: frame at the reset divider (Clause 22 write)
    wr(8'h44, 32'h0000_0905);
    wr(8'h48, 32'h0000_C0DE);
    wr(8'h50, 32'h0000_0101);
    wait_idle();
    check(busy_acc == 16257, "R13 busy length", busy_acc, 16257);
    check(period == 256, "R13 mdc period", period, 256);
    check(cap_frame == exp_frame(1'b0, 2'd1, 5'd9, 5'd5, 16'hC0DE, 16'h0),
          "R13 frame", cap_frame, exp_frame(1'b0, 2'd1, 5'd9, 5'd5, 16'hC0DE, 16'h0));

    // R3: register field widths
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, r); check(r == 32'h0000_1F1F, "R3 addr fields", r, 32'h1F1F);
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, r); check(r == 32'h0000_FFFF, "R3 wdata field", r, 32'hFFFF);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, r); check(r == 32'h0000_01FF, "R3 mode field", r, 32'h1FF);

    // R2 / R10: divider N=15, Clause 22 write
    wr(8'h40, 32'h0000_000F);
    wr(8'h44, 32'h0000_0203);
    wr(8'h48, 32'h0000_00FF);
    wr(8'h50, 32'h0000_0101);
    wait_idle();
    check(period == 16, "R2 mdc period", period, 16);
    check(low_n == 8, "R2 mdc low phase", low_n, 8);
    check(busy_acc == 1017, "R10 busy length N=15", busy_acc, 1017);

    // Vector table at N=7 (R4 R5 R6 R7 R8 R10)
    last_rd = 32'h0;
    for (int i = 0; i < 7; i++) begin
      logic        ext;
      logic [1:0]  code;
      logic [4:0]  pa, ra;
      logic [15:0] wd, pd;
      logic [63:0] ef;
      {ext, code, pa, ra, wd, pd} = VEC[i];
      phy_data    = pd;
      is_read_exp = exp_read(ext, code);
      ef = exp_frame(ext, code, pa, ra, wd, pd);
      wr(8'h40, {23'h0, ext, 8'd7});
      wr(8'h44, {19'h0, pa, 3'b000, ra});
      wr(8'h48, {16'h0, wd});
      wr(8'h50, {23'h0, 1'b1, 6'h0, code});
      wait_idle();
      check(cap_frame == ef, ext ? "R6 frame" : "R5 frame", cap_frame, ef);
      check(busy_acc == 509, "R10 busy length N=7", busy_acc, 509);
      rd(8'h4C, r);
      if (is_read_exp) begin
        check(oe_bad_rd == 1'b0, "R8 line released", oe_bad_rd, 0);
        check(r == {16'h0, pd}, "R8 read data", r, {16'h0, pd});
        last_rd = {16'h0, pd};
      end else begin
        check(oe_bad_wr == 1'b0, "R7 line driven", oe_bad_wr, 0);
        check(r == last_rd, "R8 rdata kept", r, last_rd);
      end
    end

    // R11: start while busy is ignored; R4 busy visible in command register
    phy_data = 16'h0F0F;
    wr(8'h40, 32'h0000_0007);
    wr(8'h44, 32'h0000_0A0B);
    wr(8'h48, 32'h0000_7E57);
    wr(8'h50, 32'h0000_0101);
    repeat (100) @(negedge clk);
    rd(8'h50, r); check(r == 32'h0001_0000, "R4 busy bit", r, 32'h10000);
    wr(8'h50, 32'h0000_0100);
    wait_idle();
    check(cap_frame == exp_frame(1'b0, 2'd1, 5'd10, 5'd11, 16'h7E57, 16'h0),
          "R11 frame kept", cap_frame, exp_frame(1'b0, 2'd1, 5'd10, 5'd11, 16'h7E57, 16'h0));
    check(busy_acc == 509, "R11 length kept", busy_acc, 509);
    rd(8'h50, r); check(r == 32'h0, "R4 busy cleared", r, 0);

    // R12: idle bus stays quiet
    begin
      int moves = 0;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        if (!mdc || mdio_oe) moves++;
      end
      check(moves == 0, "R12 idle quiet", moves, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule